// File: doc/BRIEF.md
# Byte Lane Match and Bit Gather Unit

This block performs two byte-oriented operations on a pair of 64-bit operands, called the source word and the table word. The first operation is a lane match. Each of the eight byte lanes of the source word is compared with the same lane of the table word. A lane that matches yields a mask byte of all ones, and a lane that differs yields a mask byte of zero.

The second operation is a bit gather. Each source byte is read as an unsigned index into the table word, with bit 0 taken as the most significant bit. The eight selected bits are packed into the lowest byte of the result. An index at or above the word width selects a constant zero.

A request is presented with a valid strobe. The result is registered and appears with its own valid strobe one clock later. The block has no flag outputs, so neither operation can touch any condition or exception state.

Top module: `lanegather_unit`

## Requirements
- R1: `res_valid` is 0 in the first cycle after reset (`rst_n` sampled low). It is asserted in the cycle directly after any cycle in which `in_valid` is 1, and it is 0 otherwise.
- R2: `res_data` holds the result of the request accepted in the previous cycle. Its value is computed from the `op_sel`, `src_a` and `src_b` values sampled in that cycle.
- R3: With `op_sel`=0 (lane match), byte k of the result, bits [8k+7:8k], is 8'hFF when `src_a[8k+7:8k]` equals `src_b[8k+7:8k]`, and 8'h00 otherwise, for k = 0..7.
- R4: With `op_sel`=1 (gather), the index for gather bit j is source byte j counted from the most significant end, that is `src_a[63-8j -: 8]`. This holds for j = 0..7.
- R5: If that index n is below 64, gather bit j equals table bit n, where bit 0 is the most significant bit, so it equals `src_b[63-n]`.
- R6: An index of 64 or above, including exactly 64, yields a gather bit of 0.
- R7: With `op_sel`=1, gather bit j is placed at `res_data[7-j]`, so gather bit 0 lands in `res_data[7]`. Bits [63:8] of the result are 0.
- R8: `res_data` keeps its value in any cycle that follows a cycle with `in_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 1 | 0 = lane match, 1 = bit gather |
| src_a | input | 64 | Source word (bytes compared, or indices) |
| src_b | input | 64 | Table word |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_data | output | 64 | Registered result |

## Verification
The hardest situation to reach is an index that lies near the range boundary, at 63, 64 or 65. This matters most when such an index shares a word with indices in range, and when lane matches differ from the table by only one bit. Random words almost never produce these cases. The bench therefore sweeps every index value 0..255 through each of the eight gather positions, over several table patterns. It also sweeps every single-bit difference in every lane for the match operation.

// File: rtl/lanegather_pkg.sv
// Package: shared widths and the operation encoding for the lane match / bit gather unit.
// Assumes the word width is a multiple of the lane width.
package lanegather_pkg;
    localparam int unsigned WORD_W = 64;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = WORD_W / LANE_W;

    typedef enum logic {
        OP_MATCH  = 1'b0,
        OP_GATHER = 1'b1
    } op_e;
endpackage

// File: rtl/lanegather_match.sv
// Module: lane match. Compares each lane of two words and emits an all-ones or
// all-zero mask per lane. Purely combinational; assumes WORD_W = LANES * LANE_W.
module lanegather_match #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 8,
    localparam int unsigned WORD_W = LANE_W * LANES
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [WORD_W-1:0] mask_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // per-lane equality to full-lane mask
        assign mask_o[k*LANE_W +: LANE_W] =
            (a_i[k*LANE_W +: LANE_W] == b_i[k*LANE_W +: LANE_W]) ? {LANE_W{1'b1}} : '0;
    end
endmodule

// File: rtl/lanegather_pick.sv
// Module: single-bit selector. Picks one bit of a table word using an MSB-first
// index; any index at or beyond the table width gives zero. Combinational.
module lanegather_pick #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned IDX_W  = 8
) (
    input  logic [WORD_W-1:0] table_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              bit_o
);
    localparam int unsigned SEL_W = $clog2(WORD_W);

    logic              in_range;
    logic [SEL_W-1:0]  sel;

    // range test and MSB-first position
    always_comb begin
        in_range = ({{(32-IDX_W){1'b0}}, idx_i} < WORD_W);
        sel      = SEL_W'(WORD_W - 1) - idx_i[SEL_W-1:0];
        bit_o    = in_range ? table_i[sel] : 1'b0;
    end
endmodule

// File: rtl/lanegather_gather.sv
// Module: bit gather. Each index byte (taken from the MSB end) picks one table bit;
// the picked bits fill the low lane MSB-first, upper bits are zero. Combinational.
module lanegather_gather #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 8,
    localparam int unsigned WORD_W = LANE_W * LANES
) (
    input  logic [WORD_W-1:0] idx_i,
    input  logic [WORD_W-1:0] table_i,
    output logic [WORD_W-1:0] gath_o
);
    logic [LANES-1:0] picked;

    for (genvar j = 0; j < LANES; j++) begin : g_pick
        lanegather_pick #(.WORD_W(WORD_W), .IDX_W(LANE_W)) pick_i (
            .table_i (table_i),
            .idx_i   (idx_i[WORD_W-1-j*LANE_W -: LANE_W]),
            .bit_o   (picked[LANES-1-j])
        );
    end

    // zero-extend the packed gather bits
    assign gath_o = {{(WORD_W-LANES){1'b0}}, picked};
endmodule

// File: rtl/lanegather_unit.sv
// Module: top of the lane match / bit gather unit. Selects one of the two
// combinational results and registers it with a one-cycle valid strobe.
// Assumes a synchronous active-low reset; data register holds when idle.
module lanegather_unit
    import lanegather_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_sel,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_data
);
    logic [WORD_W-1:0] match_res;
    logic [WORD_W-1:0] gath_res;
    logic [WORD_W-1:0] next_res;

    lanegather_match #(.LANE_W(LANE_W), .LANES(LANES)) match_i (
        .a_i    (src_a),
        .b_i    (src_b),
        .mask_o (match_res)
    );

    lanegather_gather #(.LANE_W(LANE_W), .LANES(LANES)) gather_i (
        .idx_i   (src_a),
        .table_i (src_b),
        .gath_o  (gath_res)
    );

    // operation select
    always_comb begin
        next_res = (op_e'(op_sel) == OP_GATHER) ? gath_res : match_res;
    end

    // valid strobe register
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= in_valid;
    end

    // result register, loads only on an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)        res_data <= '0;
        else if (in_valid) res_data <= next_res;
    end
endmodule

// File: rtl/lanegather_unit_chk.sv
// Checker: temporal properties of lanegather_unit, bound to every instance.
module lanegather_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        op_sel,
    input logic [63:0] src_a,
    input logic [63:0] src_b,
    input logic        res_valid,
    input logic [63:0] res_data
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    // R7
    gather_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel) |=> (res_data[63:8] == 56'd0));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(res_data));
    // R3
    match_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel && src_a == src_b) |=> (res_data == '1));
    // R6
    gather_oor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel && src_a[63:56] >= 8'd64) |=> !res_data[7]);
endmodule

bind lanegather_unit lanegather_unit_chk chk_i (.*);

// File: tb/lanegather_unit_tb_top.sv
// Bench: sweeps index values through every gather slot and single-bit lane
// differences for the match, with expected values computed arithmetically.
module lanegather_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sel = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        res_valid;
    logic [63:0] res_data;

    int n_vec = 0;
    int n_bad = 0;

    lanegather_unit dut_i (.*);

    always #4 clk = ~clk; // 125 MHz

    function automatic logic [63:0] exp_of(input logic op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        r = '0;
        if (!op) begin
            for (int k = 0; k < 8; k++)
                if (((a >> (8*k)) & 64'hFF) == ((b >> (8*k)) & 64'hFF))
                    r = r | (64'hFF << (8*k));
        end else begin
            for (int j = 0; j < 8; j++) begin
                int n;
                n = int'((a >> (56 - 8*j)) & 64'hFF);
                if (n < 64 && ((b >> (63 - n)) & 64'd1) == 64'd1)
                    r = r | (64'd1 << (7 - j));
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // apply one request, sample the registered result after the next edge
    task automatic apply(input string req, input logic op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", {63'd0, res_valid}, 64'd1);
        chk(req, res_data, exp_of(op, a, b));
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] tabs [4];
        logic [63:0] held;
        tabs[0] = 64'h8000_0000_0000_0001;
        tabs[1] = 64'hDEAD_BEEF_0123_4567;
        tabs[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        tabs[3] = 64'h5A5A_A5A5_3C3C_C3C3;
        repeat (2) @(negedge clk);
        chk("R1 reset", {63'd0, res_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", {63'd0, res_valid}, 64'd0);

        // R3: equal words, then each single-bit lane difference
        apply("R3 equal", 1'b0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF);
        for (int b = 0; b < 64; b++)
            apply("R3 onebit", 1'b0, 64'hA5C3_0F96_1E2D_7788, 64'hA5C3_0F96_1E2D_7788 ^ (64'd1 << b));
        apply("R3 alldiff", 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);

        // R4 R5 R6 R7: every index value in every slot over several tables
        for (int t = 0; t < 4; t++)
            for (int j = 0; j < 8; j++)
                for (int v = 0; v < 256; v++)
                    apply("R5/R6 gather", 1'b1,
                          (64'h0102_0304_0506_0708 & ~(64'hFF << (56 - 8*j))) | (64'(v) << (56 - 8*j)),
                          tabs[t]);
        // R6: exactly 64 in every slot gives zero
        apply("R6 idx64", 1'b1, 64'h4040_4040_4040_4040, 64'hFFFF_FFFF_FFFF_FFFF);
        // R4 R7: slot order with indices 0..7
        apply("R4 order", 1'b1, 64'h0001_0203_0405_0607, 64'hA500_0000_0000_0000);
        apply("R7 upper", 1'b1, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);

        // R8: idle cycles hold the result and drop valid
        held = res_data;
        @(negedge clk);
        src_a = '1; src_b = '0; op_sel = 1'b0;
        @(negedge clk);
        chk("R8 hold", res_data, held);
        chk("R1 drop", {63'd0, res_valid}, 64'd0);
        // R2: back-to-back requests each land one cycle later
        @(negedge clk);
        in_valid = 1'b1; op_sel = 1'b0; src_a = 64'h11; src_b = 64'h11;
        @(negedge clk);
        chk("R2 b2b0", res_data, exp_of(1'b0, 64'h11, 64'h11));
        op_sel = 1'b1; src_a = 64'h3F00_0000_0000_0000; src_b = 64'h1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 b2b1", res_data, 64'h80);
        chk("R1 b2b", {63'd0, res_valid}, 64'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule